// File: doc/BRIEF.md
# DRAM Impedance Calibration Scheduler

This block lives inside a DDR3-class memory controller and decides when the controller sends the two impedance calibration commands to the DRAM. The first is a long calibration. The second is a short calibration. Right after reset the block asks for one long calibration, which gets the extended initial quiet window. From then on it asks for short calibrations at a programmable interval, counted in ticks of a slow timebase. The controller can also request further long calibrations at any time. Those later long calibrations get their own, shorter quiet window.

Before it asks for a command slot, the block waits until every bank reports idle and the row-precharge time has run out since the last precharge. If some bank is still open, it asks the controller for a precharge-all. When the arbiter grants a calibration command, the block raises a channel-wide blackout for the matching window length, and the arbiter must not grant any other command while the blackout is high. All timing values are cycle counts that are captured while reset is held.

Top module: `zqcal_sched`

## Requirements
- R1: The first calibration command granted after reset is a long one (`cal_kind` = 1), and its blackout lasts `cfg_first_long_win` cycles.
- R2: Every later long calibration has a blackout of `cfg_long_win` cycles.
- R3: A short calibration (`cal_kind` = 0) has a blackout of `cfg_short_win` cycles, raised to 64 when the programmed value is below 64.
- R4: `channel_block` rises in the cycle after the clock edge where `cal_req` and `cal_gnt` are both high, and it stays high for exactly the window length. `cal_req` is low while `channel_block` is high.
- R5: `cal_req` is high only when all `bank_idle` bits are 1 and at least `cfg_trp` cycles have passed since the last `pre_done` pulse. While a calibration is pending and some bank is busy, `pre_all_req` is high. `pre_all_req` is never high during a blackout.
- R6: A short calibration becomes pending once `cfg_interval` ticks have been counted since the last calibration was granted. The count restarts whenever any calibration is granted.
- R7: A one-cycle pulse on `ext_long_req` makes a long calibration pending at any time. A pending long calibration goes ahead of a pending short one. Granting a long calibration drops a pending short one.
- R8: While `cal_req` is high, `cal_kind` shows what will be issued: 1 means long and 0 means short.
- R9: The configuration inputs are sampled only while `rst_n` is low. Changing them after reset has no effect on window lengths, tRP or the interval.
- R10: While reset is held, `cal_req`, `pre_all_req` and `channel_block` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| tick | input | 1 | One-cycle pulse of the slow timebase for the short-calibration interval |
| cfg_first_long_win | input | WIN_W | Blackout length of the first long calibration after reset, in cycles |
| cfg_long_win | input | WIN_W | Blackout length of later long calibrations, in cycles |
| cfg_short_win | input | WIN_W | Blackout length of short calibrations (minimum 64 applied) |
| cfg_trp | input | TRP_W | Required cycles between a precharge and a calibration command |
| cfg_interval | input | IVL_W | Short-calibration interval, in ticks |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 when the bank is precharged |
| pre_done | input | 1 | Pulse when a precharge command was placed on the channel |
| ext_long_req | input | 1 | Pulse requesting an additional long calibration |
| cal_gnt | input | 1 | Arbiter grant for the calibration command slot |
| cal_req | output | 1 | Calibration command request to the arbiter |
| cal_kind | output | 1 | 1 = long calibration, 0 = short calibration |
| pre_all_req | output | 1 | Request for a precharge-all before calibrating |
| channel_block | output | 1 | Channel blackout; no other command may be granted |

## Verification
The bench checks that the first long window uses the initial length and that later ones use the shorter long length. A design that kept the first-after-reset flag set, or never set it, gives a blackout of the wrong length. It programs a short window below 64 and then rewrites every configuration input after reset. A missing clamp, or configuration that is not latched, shows up as a 10-cycle or 200-cycle window, a zero tRP gap, or a premature short request. With banks left open it expects a precharge-all request, no request before tRP has run out, and a short command only after the interval. A design that skipped the precharge check would request while banks are busy, and an interval that does not restart would fire early. Finally it holds off the grant while a short request is waiting and injects a long request. A design without long-over-short priority, or one that kept the dropped short pending, would issue the wrong kind or would issue a short right after the long window.

// File: rtl/zqs_pkg.sv
// Shared types and constants for the impedance calibration scheduler.
package zqs_pkg;

    // Scheduler states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // nothing pending
        ST_PREP = 2'd1,   // waiting for banks idle and tRP
        ST_REQ  = 2'd2,   // requesting the command slot
        ST_WIN  = 2'd3    // blackout window running
    } zqs_state_t;

    // Calibration kind as seen on cal_kind
    typedef enum logic {
        CAL_SHORT = 1'b0,
        CAL_LONG  = 1'b1
    } zqs_kind_t;

    // A short calibration needs at least this many cycles to take effect
    localparam int MIN_SHORT_WIN = 64;

endpackage

// File: rtl/zqs_interval_timer.sv
// Periodic interval timer.
// Counts tick pulses and gives a one-cycle pulse on due once cfg_ivl ticks
// have been counted since the last restart. An interval of zero acts as one.
// Assumes tick is a single-cycle pulse of a slow timebase.
module zqs_interval_timer #(
    parameter int IVL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [IVL_W-1:0] cfg_ivl,
    output logic             due
);

    logic [IVL_W-1:0] tick_cnt;
    logic [IVL_W-1:0] ivl_eff;

    // Treat a zero interval as one tick
    always_comb begin
        ivl_eff = (cfg_ivl == '0) ? IVL_W'(1) : cfg_ivl;
    end

    // Count ticks since the last restart and flag expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            due      <= 1'b0;
        end else begin
            due <= 1'b0;
            if (restart) begin
                tick_cnt <= '0;
            end else if (tick) begin
                if (tick_cnt >= ivl_eff - IVL_W'(1)) begin
                    tick_cnt <= '0;
                    due      <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + IVL_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/zqs_prech_guard.sv
// Precharge guard.
// Reports ready when every bank is idle and at least cfg_trp cycles have
// passed since the last precharge pulse. After reset tRP counts as elapsed.
// Assumes pre_done marks the cycle a precharge went out on the channel.
module zqs_prech_guard #(
    parameter int NUM_BANKS = 8,
    parameter int TRP_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 pre_done,
    input  logic [TRP_W-1:0]     cfg_trp,
    output logic                 all_idle,
    output logic                 ready
);

    logic [TRP_W-1:0] trp_left;

    // Reduce the per-bank idle flags
    always_comb begin
        all_idle = &bank_idle;
    end

    // Count down the precharge time after each precharge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trp_left <= '0;
        end else if (pre_done) begin
            trp_left <= cfg_trp;
        end else if (trp_left != '0) begin
            trp_left <= trp_left - TRP_W'(1);
        end
    end

    // Ready once banks are idle and tRP has run out
    always_comb begin
        ready = all_idle && (trp_left == '0) && !pre_done;
    end

endmodule

// File: rtl/zqs_window_timer.sv
// Blackout window timer.
// Loads a cycle count when a calibration is granted. It is busy while the
// count is non-zero and flags the last busy cycle. Assumes load_val >= 1.
module zqs_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    output logic             busy,
    output logic             last
);

    logic [WIN_W-1:0] remain;

    // Load on grant, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - WIN_W'(1);
        end
    end

    // Decode busy and final-cycle flags
    always_comb begin
        busy = (remain != '0);
        last = (remain == WIN_W'(1));
    end

endmodule

// File: rtl/zqcal_sched.sv
// Impedance calibration scheduler (top).
// Asks for one long calibration after reset and then short calibrations on
// a tick-based interval. It also accepts extra long requests. Each command
// waits for all banks idle plus tRP and then raises a channel blackout for
// the matching window.
// Assumes the arbiter grants nothing else while channel_block is high and
// sends a precharge-all when pre_all_req is high.
module zqcal_sched
    import zqs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int WIN_W     = 16,
    parameter int TRP_W     = 8,
    parameter int IVL_W     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [WIN_W-1:0]     cfg_first_long_win,
    input  logic [WIN_W-1:0]     cfg_long_win,
    input  logic [WIN_W-1:0]     cfg_short_win,
    input  logic [TRP_W-1:0]     cfg_trp,
    input  logic [IVL_W-1:0]     cfg_interval,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 pre_done,
    input  logic                 ext_long_req,
    input  logic                 cal_gnt,
    output logic                 cal_req,
    output logic                 cal_kind,
    output logic                 pre_all_req,
    output logic                 channel_block
);

    localparam logic [WIN_W-1:0] SHORT_FLOOR = WIN_W'(MIN_SHORT_WIN);
    localparam logic [WIN_W-1:0] ONE_CYCLE   = WIN_W'(1);

    // Captured configuration
    logic [WIN_W-1:0] first_win_q, long_win_q, short_win_q;
    logic [TRP_W-1:0] trp_q;
    logic [IVL_W-1:0] ivl_q;

    zqs_state_t state_q, state_d;
    logic       first_q, long_pend_q, short_pend_q;
    logic       issue, issue_long;
    logic       all_idle, ready, due, win_busy, win_last;
    logic [WIN_W-1:0] win_len;
    zqs_kind_t  kind_now;

    // Capture configuration while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_win_q <= cfg_first_long_win;
            long_win_q  <= cfg_long_win;
            short_win_q <= cfg_short_win;
            trp_q       <= cfg_trp;
            ivl_q       <= cfg_interval;
        end
    end

    zqs_interval_timer #(.IVL_W(IVL_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (issue),
        .cfg_ivl (ivl_q),
        .due     (due)
    );

    zqs_prech_guard #(.NUM_BANKS(NUM_BANKS), .TRP_W(TRP_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_idle (bank_idle),
        .pre_done  (pre_done),
        .cfg_trp   (trp_q),
        .all_idle  (all_idle),
        .ready     (ready)
    );

    zqs_window_timer #(.WIN_W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .load_val (win_len),
        .busy     (win_busy),
        .last     (win_last)
    );

    // Pick the kind to issue: long beats short
    always_comb begin
        kind_now = long_pend_q ? CAL_LONG : CAL_SHORT;
    end

    // Drive request, kind and precharge-all outputs from state
    always_comb begin
        cal_req     = (state_q == ST_REQ) && ready;
        cal_kind    = kind_now;
        pre_all_req = (state_q == ST_PREP) && !all_idle;
        issue       = cal_req && cal_gnt;
        issue_long  = issue && (kind_now == CAL_LONG);
    end

    // Select window length for the command being granted
    always_comb begin
        if (kind_now == CAL_LONG) begin
            win_len = first_q ? first_win_q : long_win_q;
            if (win_len == '0) begin
                win_len = ONE_CYCLE;
            end
        end else begin
            win_len = (short_win_q < SHORT_FLOOR) ? SHORT_FLOOR : short_win_q;
        end
    end

    // Track pending long and short calibrations and the first-after-reset flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q      <= 1'b1;
            long_pend_q  <= 1'b1;
            short_pend_q <= 1'b0;
        end else begin
            if (issue_long) begin
                first_q <= 1'b0;
            end
            if (ext_long_req) begin
                long_pend_q <= 1'b1;
            end else if (issue_long) begin
                long_pend_q <= 1'b0;
            end
            if (issue) begin
                short_pend_q <= 1'b0;
            end else if (due) begin
                short_pend_q <= 1'b1;
            end
        end
    end

    // Next-state decision for the scheduler
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (long_pend_q || short_pend_q) state_d = ST_PREP;
            ST_PREP: if (ready) state_d = ST_REQ;
            ST_REQ: begin
                if (!ready) begin
                    state_d = ST_PREP;
                end else if (cal_gnt) begin
                    state_d = ST_WIN;
                end
            end
            ST_WIN:  if (win_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the scheduler state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Blackout follows the window timer
    always_comb begin
        channel_block = win_busy;
    end

endmodule

// File: rtl/zqs_checker.sv
// Property checker for the calibration scheduler, bound to zqcal_sched.
// It keeps its own precharge-gap counter and its own copy of tRP.
module zqs_checker #(
    parameter int NUM_BANKS = 8,
    parameter int TRP_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cal_req,
    input logic                 cal_gnt,
    input logic                 pre_all_req,
    input logic                 channel_block,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic                 pre_done,
    input logic [TRP_W-1:0]     cfg_trp
);

    logic [TRP_W:0]   gap;
    logic [TRP_W-1:0] trp_seen;

    // Own copy of tRP, captured during reset
    always_ff @(posedge clk) begin
        if (!rst_n) trp_seen <= cfg_trp;
    end

    // Cycles since last precharge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '1;
        end else if (pre_done) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    a_r4_no_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        channel_block |-> !cal_req);

    a_r4_block_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req && cal_gnt) |=> channel_block);

    a_r4_block_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(channel_block) |-> $past(cal_req && cal_gnt));

    a_r5_req_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> (&bank_idle));

    a_r5_req_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> (gap >= {1'b0, trp_seen}));

    a_r5_no_prech_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        channel_block |-> !pre_all_req);

endmodule

bind zqcal_sched zqs_checker #(.NUM_BANKS(NUM_BANKS), .TRP_W(TRP_W)) u_zqs_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cal_req       (cal_req),
    .cal_gnt       (cal_gnt),
    .pre_all_req   (pre_all_req),
    .channel_block (channel_block),
    .bank_idle     (bank_idle),
    .pre_done      (pre_done),
    .cfg_trp       (cfg_trp)
);

// File: tb/zqcal_sched_test.sv
// Scoreboard bench for zqcal_sched: the driver queues expected commands,
// and the monitor pops each one on a grant and measures its blackout.
module zqcal_sched_test;

    localparam int NB = 8, WW = 16, TW = 8, IW = 24;
    localparam int FIRST_WIN = 300, LONG_WIN = 150, SHORT_CFG = 10, SHORT_EXP = 64;
    localparam int TRP = 5, IVL = 40, TICK_DIV = 4;
    localparam int IVL_MIN = IVL * TICK_DIV - 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [WW-1:0] cfg_first_long_win, cfg_long_win, cfg_short_win;
    logic [TW-1:0] cfg_trp;
    logic [IW-1:0] cfg_interval;
    logic [NB-1:0] bank_idle = '1;
    logic pre_done = 1'b0, ext_long_req = 1'b0, cal_gnt = 1'b1;
    logic cal_req, cal_kind, pre_all_req, channel_block;

    typedef struct { bit kind; int win; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, cyc = 0, windows_done = 0;
    int last_issue = -1, last_pre = -1;

    always #4 clk = ~clk;

    zqcal_sched #(.NUM_BANKS(NB), .WIN_W(WW), .TRP_W(TW), .IVL_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_first_long_win(cfg_first_long_win), .cfg_long_win(cfg_long_win),
        .cfg_short_win(cfg_short_win), .cfg_trp(cfg_trp), .cfg_interval(cfg_interval),
        .bank_idle(bank_idle), .pre_done(pre_done), .ext_long_req(ext_long_req),
        .cal_gnt(cal_gnt), .cal_req(cal_req), .cal_kind(cal_kind),
        .pre_all_req(pre_all_req), .channel_block(channel_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input bit kind, input int win);
        exp_t e;
        e.kind = kind;
        e.win  = win;
        exp_q.push_back(e);
    endtask

    task automatic pulse_ext();
        @(posedge clk); #1 ext_long_req = 1'b1;
        @(posedge clk); #1 ext_long_req = 1'b0;
    endtask

    // Tick generator: one pulse every TICK_DIV cycles
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
        end
    end

    // Monitor: pop expected item on grant, then measure blackout length
    initial begin
        bit in_win = 1'b0;
        int wlen = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (in_win) begin
                    if (channel_block) begin
                        wlen++;
                        if (cal_req) chk(1'b0, "R4", "cal_req during blackout", 1, 0);
                    end else begin
                        chk(wlen == cur.win, cur.kind ? (windows_done == 0 ? "R1" : "R2") : "R3",
                            "blackout length", wlen, cur.win);
                        chk(wlen == cur.win, "R4", "blackout duration", wlen, cur.win);
                        windows_done++;
                        in_win = 1'b0;
                    end
                end else if (cal_req && cal_gnt) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected command", int'(cal_kind), -1);
                    end else begin
                        cur = exp_q.pop_front();
                        chk(cal_kind == cur.kind, "R8", "command kind", int'(cal_kind), int'(cur.kind));
                        if (!cur.kind && last_issue >= 0)
                            chk(cyc - last_issue >= IVL_MIN, "R6", "interval gap",
                                cyc - last_issue, IVL_MIN);
                        if (last_pre > last_issue)
                            chk(cyc - last_pre > TRP, "R5", "gap after precharge",
                                cyc - last_pre, TRP + 1);
                        last_issue = cyc;
                        in_win = 1'b1;
                        wlen = 0;
                    end
                end
            end
        end
    end

    // Driver
    initial begin
        cfg_first_long_win = WW'(FIRST_WIN);
        cfg_long_win       = WW'(LONG_WIN);
        cfg_short_win      = WW'(SHORT_CFG);
        cfg_trp            = TW'(TRP);
        cfg_interval       = IW'(IVL);
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R10: outputs quiet during reset
        chk(cal_req == 1'b0, "R10", "cal_req in reset", int'(cal_req), 0);
        chk(pre_all_req == 1'b0, "R10", "pre_all_req in reset", int'(pre_all_req), 0);
        chk(channel_block == 1'b0, "R10", "channel_block in reset", int'(channel_block), 0);
        push_exp(1'b1, FIRST_WIN);             // R1
        @(posedge clk); #1 rst_n = 1'b1;
        // R9: rewrite configuration after reset; must be ignored
        cfg_first_long_win = WW'(7);
        cfg_long_win       = WW'(20);
        cfg_short_win      = WW'(200);
        cfg_trp            = TW'(0);
        cfg_interval       = IW'(2);
        wait (windows_done >= 1);

        // R2, R9: extra long uses later-long window
        push_exp(1'b1, LONG_WIN);
        pulse_ext();
        // R3, R6: short after interval, clamped to 64
        push_exp(1'b0, SHORT_EXP);
        wait (windows_done >= 3);

        // R5: banks open when interval expires
        @(posedge clk); #1 bank_idle = 8'b1111_0111;
        push_exp(1'b0, SHORT_EXP);
        while (!pre_all_req) @(negedge clk);
        chk(pre_all_req == 1'b1, "R5", "precharge-all requested", int'(pre_all_req), 1);
        chk(cal_req == 1'b0, "R5", "no request while bank busy", int'(cal_req), 0);
        repeat (3) @(negedge clk);
        chk(cal_req == 1'b0, "R5", "still no request while bank busy", int'(cal_req), 0);
        @(posedge clk); #1 bank_idle = '1; pre_done = 1'b1; last_pre = cyc;
        @(posedge clk); #1 pre_done = 1'b0;
        wait (windows_done >= 4);

        // R7, R8: long request overtakes a waiting short
        @(posedge clk); #1 cal_gnt = 1'b0;
        while (!cal_req) @(negedge clk);
        chk(cal_kind == 1'b0, "R8", "waiting kind is short", int'(cal_kind), 0);
        pulse_ext();
        @(negedge clk);
        chk(cal_kind == 1'b1, "R7", "long overtakes short", int'(cal_kind), 1);
        push_exp(1'b1, LONG_WIN);
        push_exp(1'b0, SHORT_EXP);             // R7: dropped short not reissued early
        @(posedge clk); #1 cal_gnt = 1'b1;
        wait (windows_done >= 6);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", windows_done, 6);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule